// File: doc/BRIEF.md
# Automatic Baud Rate Detector

This block finds the bit rate of a far-end serial sender from a single calibration character. Once armed, it watches an idle-high serial input. The far end sends an ASCII space (0x20): a start bit, then data bits LSB first. Because of that bit pattern, the line stays low for exactly six bit periods (the start bit plus the five low data bits). The block counts the system clocks between the first falling edge and the following rising edge of the synchronized line.

It then compares that count, one entry per cycle, against eight candidate rates from 150 to 19200 baud. The rates double at each step. Each entry is the number of clocks that six bit periods last at that rate, and each has a symmetric tolerance window. The first entry whose window contains the count is the result. The block reports the rate index together with an 8-bit control byte that downstream clock-selection logic uses. If no entry matches, or the line stays low too long, it raises an error instead.

The table entries and the tolerances are derived from the clock frequency parameter. After a result or an error, the block ignores the line until the next arm pulse.

Top module: `autobaud_detector`

## Requirements
- R1: After reset, `done`, `err`, `rate_idx` and `rate_ctrl` are all 0, and the block ignores the line until `start` is seen.
- R2: After arming, the block counts one per clock while the two-flop-synchronized line is low, starting at the first falling edge and stopping at the next rising edge. For a low run of exactly 6*(CLK_HZ/(150*2^i)) clocks it reports `done`=1 with `rate_idx`=i, for each i from 0 (150 baud) to 7 (19200 baud).
- R3: With `done`, `rate_ctrl` equals the code for `rate_idx`: 0x14, 0x3C, 0x5B, 0x7A, 0x99, 0xB8, 0xC4, 0xEC for indices 0 to 7. Bits 7:5 of each code equal the index.
- R4: Entry i matches when the count C satisfies E-T <= C <= E+T, inclusive at both ends. Here E=6*(CLK_HZ/(150*2^i)) and T=E>>TOL_SHIFT. Entries are tried from index 0 upward, and the first match wins.
- R5: When no entry matches, `err`=1, `done`=0, `rate_idx`=0 and `rate_ctrl`=0.
- R6: The low-run counter saturates at LIMIT. If the line is still low on the clock after the count reaches LIMIT, `err` is raised without waiting for a rising edge.
- R7: While `done` or `err` is set and `start` is low, further line activity changes none of the outputs.
- R8: A cycle with `start`=1 clears `done` and `err` on the next cycle and restarts the wait for a falling edge. While `start` is held, it overrides a rising edge that arrives in the same cycle.
- R9: `done` and `err` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm pulse; clears the result and waits for a falling edge |
| rxd | input | 1 | Serial input, idle high, asynchronous |
| done | output | 1 | A rate was matched |
| err | output | 1 | No match or low-run timeout |
| rate_idx | output | 3 | Index of the matched rate (0 = 150 baud … 7 = 19200 baud) |
| rate_ctrl | output | 8 | Control byte of the matched rate |

## Verification
The arm input and the end of the measurement can fall in the same cycle: `start` is high in the cycle where the synchronized line rises. The bench provokes this by holding `start` across the rising edge of a low run that is valid for 9600 baud. The expected outcome is that `done` and `err` both stay low, because the arm has priority. The block must also still be waiting for a fresh falling edge, so a later 19200-baud run, sent without a new arm, must then report index 7. A second collision is at the saturation limit, where a long low run has to end in an error while the line is still low.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  localparam int NUM_RATES = 8;
  localparam int IDX_W     = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2,
    ST_SRCH = 2'd3
  } abd_state_e;

  // Control byte per rate index; bits 7:5 carry the index itself.
  function automatic logic [7:0] rate_code(input logic [IDX_W-1:0] i);
    logic [7:0] c;
    case (i)
      3'd0:    c = 8'h14;
      3'd1:    c = 8'h3C;
      3'd2:    c = 8'h5B;
      3'd3:    c = 8'h7A;
      3'd4:    c = 8'h99;
      3'd5:    c = 8'hB8;
      3'd6:    c = 8'hC4;
      default: c = 8'hEC;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/abd_line_sync.sv
module abd_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_low,
  output logic fall,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  // Reset to idle-high so no false edge appears after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_low = ~s2_q;
  assign fall     = ~s2_q &  s3_q;
  assign rise     =  s2_q & ~s3_q;
endmodule

// File: rtl/abd_low_timer.sv
module abd_low_timer #(
  parameter int unsigned LIMIT = 15360,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign at_limit = (cnt_q == CNT_W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CNT_W'(1);
    else if (inc && !at_limit)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load || inc)
      cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/abd_rate_table.sv
module abd_rate_table
  import autobaud_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 192000,
  parameter int unsigned BASE_BAUD = 150,
  parameter int unsigned SPAN_BITS = 6,
  parameter int unsigned TOL_SHIFT = 3,
  parameter int          CNT_W     = 14
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [7:0]       code
);
  logic [31:0] ent_tab [NUM_RATES];
  logic [31:0] tol_tab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_entry
    localparam int unsigned ENT = SPAN_BITS * (CLK_HZ / (BASE_BAUD << g));
    localparam int unsigned TOL = ENT >> TOL_SHIFT;
    assign ent_tab[g] = 32'(ENT);
    assign tol_tab[g] = 32'(TOL);
  end

  logic [31:0] ent, tol, shifted, diff;

  always_comb begin
    ent     = ent_tab[idx];
    tol     = tol_tab[idx];
    shifted = 32'(count) + tol;
    diff    = shifted - ent;
    hit     = (shifted >= ent) && (diff <= (tol << 1));
    code    = rate_code(idx);
  end
endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
  import autobaud_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 192000,
  parameter int unsigned BASE_BAUD = 150,
  parameter int unsigned SPAN_BITS = 6,
  parameter int unsigned TOL_SHIFT = 3,
  parameter int unsigned LIMIT     = 2 * SPAN_BITS * (CLK_HZ / BASE_BAUD),
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rxd,
  output logic       done,
  output logic       err,
  output logic [2:0] rate_idx,
  output logic [7:0] rate_ctrl
);
  logic line_low, fall, rise;
  logic tmr_load, tmr_inc, at_limit;
  logic [CNT_W-1:0] low_cnt;
  logic hit;
  logic [7:0] code;

  abd_state_e state_q, state_d;
  logic [IDX_W-1:0] sidx_q, sidx_d;
  logic [IDX_W-1:0] ridx_q, ridx_d;
  logic [7:0] rctrl_q, rctrl_d;
  logic done_q, done_d, err_q, err_d;

  abd_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rxd),
    .line_low(line_low), .fall(fall), .rise(rise)
  );

  abd_low_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .inc(tmr_inc),
    .count(low_cnt), .at_limit(at_limit)
  );

  abd_rate_table #(
    .CLK_HZ(CLK_HZ), .BASE_BAUD(BASE_BAUD), .SPAN_BITS(SPAN_BITS),
    .TOL_SHIFT(TOL_SHIFT), .CNT_W(CNT_W)
  ) u_table (
    .idx(sidx_q), .count(low_cnt), .hit(hit), .code(code)
  );

  always_comb begin
    state_d  = state_q;
    sidx_d   = sidx_q;
    ridx_d   = ridx_q;
    rctrl_d  = rctrl_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_inc  = 1'b0;
    if (start) begin
      state_d = ST_WAIT;
      sidx_d  = '0;
      ridx_d  = '0;
      rctrl_d = '0;
      done_d  = 1'b0;
      err_d   = 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (fall) begin
            tmr_load = 1'b1;
            state_d  = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (rise) begin
            sidx_d  = '0;
            state_d = ST_SRCH;
          end else if (at_limit) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (line_low) begin
            tmr_inc = 1'b1;
          end
        end
        ST_SRCH: begin
          if (hit) begin
            done_d  = 1'b1;
            ridx_d  = sidx_q;
            rctrl_d = code;
            state_d = ST_IDLE;
          end else if (sidx_q == IDX_W'(NUM_RATES - 1)) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            sidx_d = sidx_q + IDX_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sidx_q  <= '0;
      ridx_q  <= '0;
      rctrl_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sidx_q  <= sidx_d;
      ridx_q  <= ridx_d;
      rctrl_q <= rctrl_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign rate_idx  = ridx_q;
  assign rate_ctrl = rctrl_q;
endmodule

// File: rtl/abd_checker.sv
module abd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic       err,
  input logic [2:0] rate_idx,
  input logic [7:0] rate_ctrl
);
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_arm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !err));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(rate_idx) && $stable(rate_ctrl)));

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  assert_code_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rate_ctrl[7:5] == rate_idx));

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rate_idx == 3'd0 && rate_ctrl == 8'h00));
endmodule

bind autobaud_detector abd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
  .rate_idx(rate_idx), .rate_ctrl(rate_ctrl)
);

// File: tb/autobaud_detector_tb.sv
module autobaud_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 192000;

  logic clk, rst_n, start, rxd;
  logic done, err;
  logic [2:0] rate_idx;
  logic [7:0] rate_ctrl;
  int checks = 0;
  int errors = 0;

  autobaud_detector u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rxd(rxd),
    .done(done), .err(err), .rate_idx(rate_idx), .rate_ctrl(rate_ctrl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ent6(input int i);
    return 6 * (HZ / (150 << i));
  endfunction

  function automatic int exp_code(input int i);
    int t [8] = '{8'h14, 8'h3C, 8'h5B, 8'h7A, 8'h99, 8'hB8, 8'hC4, 8'hEC};
    return t[i];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_low(input int n);
    @(negedge clk) rxd = 1'b0;
    repeat (n) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic wait_result();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  task automatic expect_rate(input string tag, input int n, input int i);
    arm();
    send_low(n);
    wait_result();
    chk({tag, " done"}, done, 1);
    chk({tag, " err"}, err, 0);
    chk({tag, " idx"}, rate_idx, i);
    chk({"R3 ", tag, " code"}, rate_ctrl, exp_code(i));
  endtask

  task automatic expect_error(input string tag, input int n);
    arm();
    send_low(n);
    wait_result();
    chk({tag, " err"}, err, 1);
    chk({tag, " done"}, done, 0);
    chk({tag, " idx"}, rate_idx, 0);
    chk({tag, " code"}, rate_ctrl, 0);
  endtask

  task automatic t_reset_and_idle();
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 idx", rate_idx, 0);
    chk("R1 code", rate_ctrl, 0);
    send_low(ent6(6));
    repeat (20) @(negedge clk);
    chk("R1 unarmed done", done, 0);
    chk("R1 unarmed err", err, 0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++) expect_rate("R2", ent6(i), i);
  endtask

  task automatic t_window();
    expect_rate("R4 upper edge", ent6(7) + (ent6(7) >> 3), 7);
    expect_rate("R4 lower edge", ent6(7) - (ent6(7) >> 3), 7);
    expect_rate("R4 low edge 1200", ent6(3) - (ent6(3) >> 3), 3);
    expect_error("R5 above window", ent6(7) + (ent6(7) >> 3) + 1);
    expect_error("R5 below window", ent6(7) - (ent6(7) >> 3) - 1);
  endtask

  task automatic t_timeout();
    arm();
    @(negedge clk) rxd = 1'b0;
    repeat (2 * ent6(0) + 40) @(negedge clk);
    chk("R6 err while low", err, 1);
    chk("R6 done while low", done, 0);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 err held", err, 1);
  endtask

  task automatic t_ignore_after();
    expect_rate("R7 setup", ent6(6), 6);
    send_low(ent6(7));
    repeat (20) @(negedge clk);
    chk("R7 done held", done, 1);
    chk("R7 idx held", rate_idx, 6);
    chk("R7 code held", rate_ctrl, exp_code(6));
  endtask

  task automatic t_collision();
    arm();
    @(negedge clk) rxd = 1'b0;
    repeat (ent6(6) - 2) @(negedge clk);
    start = 1'b1;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 no done", done, 0);
    chk("R8 no err", err, 0);
    send_low(ent6(7));
    wait_result();
    chk("R8 rearmed done", done, 1);
    chk("R8 rearmed idx", rate_idx, 7);
    chk("R9 not both", int'(done && err), 0);
  endtask

  initial begin
    start = 1'b0;
    rxd   = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_and_idle();
    t_sweep();
    t_window();
    t_timeout();
    t_ignore_after();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule